// File: doc/BRIEF.md
# FIFO Threshold Interrupt Controller

This block raises interrupts for a serial-port controller that has a transmit FIFO and a receive FIFO, each 64 entries deep. It watches the occupancy counts of both FIFOs and a one-cycle transfer-complete strobe. From these it keeps three sticky status flags: receive FIFO nearly full, transmit FIFO nearly drained, and transfer finished. Software clears a flag by writing a one to its bit. An enable register picks which flags may drive the single interrupt line.

The FIFOs and the bus decoder sit outside the block. The decoder turns a status-register write into a one-cycle clear strobe with its data word, and an enable-register write into a one-cycle enable strobe with its data word. The block also passes both occupancy counts back as one packed read word, so software can see how much to drain or refill.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the status word, the enable word and `irq_o` to zero.
- R2: Status bit 4 is set on the clock edge after `rx_level` is 48 or more. A level of 47 does not set it. Once set, the bit stays set after the level falls.
- R3: Status bit 12 is set on the clock edge after `tx_level` is 16 or less. A level of 17 does not set it. Once set, the bit stays set after the level rises.
- R4: A one-cycle high pulse on `xfer_done` sets status bit 16 on the next edge. The bit stays set after the pulse ends.
- R5: A status write (`sts_clr_we` high) clears each flag whose bit in `sts_clr_data` is 1. Flags whose bits are 0 are left unchanged. Writing all ones clears every flag whose source is inactive.
- R6: The threshold flags follow the level. Clearing bit 4 or bit 12 while its threshold condition still holds leaves the bit reading 1 after the write.
- R7: An enable write (`en_we` high) loads bits 4, 12 and 16 of `en_wdata` into the enable word. All other enable bits read as 0.
- R8: `irq_o` is high exactly when some status bit and the matching enable bit are both 1.
- R9: `fifo_word_o` holds `rx_level` in bits 6:0 and `tx_level` in bits 22:16. All other bits are 0. It follows the inputs in the same cycle, and a count of 64 is shown as is.
- R10: If a transfer-complete pulse arrives in the same cycle as a write that clears bit 16, bit 16 reads 1 afterwards.
- R11: Status bits other than 4, 12 and 16 always read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_level | input | 7 | Receive FIFO occupancy, 0 to 64 |
| tx_level | input | 7 | Transmit FIFO occupancy, 0 to 64 |
| xfer_done | input | 1 | One-cycle transfer-complete strobe |
| sts_clr_we | input | 1 | Status write strobe (write-one-to-clear) |
| sts_clr_data | input | 32 | Status write data |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 32 | Enable register write data |
| status_o | output | 32 | Latched status word |
| enable_o | output | 32 | Enable word |
| irq_o | output | 1 | Combined interrupt request |
| fifo_word_o | output | 32 | Packed FIFO occupancy word |

## Verification
The three flag bits and three enable bits are the only state in the block. A wrong flag appears on `status_o` one edge after its stimulus, and on `irq_o` at the same moment when the bit is enabled. A lost edge, a clear applied to the wrong bit, or a clear that wins over a set shows up as a single wrong bit in the first read after that edge. An off-by-one threshold is exposed by driving levels 47/48 and 16/17. A swapped count field shows up in the same cycle on `fifo_word_o`.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;

    localparam int DEF_DEPTH = 64;
    localparam int DEF_REG_W = 32;
    localparam int NUM_SRC   = 3;

    // Source indices into the flag vector
    localparam int SRC_RXF  = 0;
    localparam int SRC_TXE  = 1;
    localparam int SRC_DONE = 2;

    // Bit offsets of the count fields inside the packed FIFO word
    localparam int RX_CNT_LSB = 0;
    localparam int TX_CNT_LSB = 16;

    typedef struct packed {
        logic done;
        logic tx_low;
        logic rx_high;
    } evt_t;

    // Register bit position of each interrupt source
    function automatic int src_pos(input int idx);
        case (idx)
            SRC_RXF: return 4;
            SRC_TXE: return 12;
            default: return 16;
        endcase
    endfunction

    function automatic logic [DEF_REG_W-1:0] src_mask();
        logic [DEF_REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_SRC; i++) m[src_pos(i)] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/fifo_irq_thresh.sv
module fifo_irq_thresh
    import fifo_irq_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] rx_level,
    input  logic [CNT_W-1:0] tx_level,
    input  logic             done_pulse,
    output evt_t             evt
);

    localparam int RX_HI = (DEPTH * 3) / 4;
    localparam int TX_LO = DEPTH / 4;

    always_comb begin
        evt.rx_high = (rx_level >= CNT_W'(RX_HI));
        evt.tx_low  = (tx_level <= CNT_W'(TX_LO));
        evt.done    = done_pulse;
    end

endmodule

// File: rtl/fifo_irq_flags.sv
module fifo_irq_flags
    import fifo_irq_pkg::*;
#(
    parameter int REG_W = DEF_REG_W,
    parameter int NSRC  = NUM_SRC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  set_i,
    input  logic             clr_we,
    input  logic [REG_W-1:0] clr_data,
    output logic [NSRC-1:0]  flag_q
);

    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        localparam int POS = src_pos(i);
        logic clr_hit;

        assign clr_hit = clr_we & clr_data[POS];

        // A new set event wins over a clear in the same cycle
        always_ff @(posedge clk) begin
            if (rst) flag_q[i] <= 1'b0;
            else     flag_q[i] <= set_i[i] | (flag_q[i] & ~clr_hit);
        end

        // R6 R10
        set_wins_chk: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> flag_q[i]);

        // R5
        clr_takes_chk: assert property (@(posedge clk) disable iff (rst)
            (clr_hit && !set_i[i]) |=> !flag_q[i]);
    end

endmodule

// File: rtl/fifo_irq_mask.sv
module fifo_irq_mask
    import fifo_irq_pkg::*;
#(
    parameter int REG_W = DEF_REG_W,
    parameter int NSRC  = NUM_SRC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_we,
    input  logic [REG_W-1:0] en_wdata,
    input  logic [NSRC-1:0]  flags,
    output logic [NSRC-1:0]  en_q,
    output logic             irq_o
);

    logic [NSRC-1:0] en_bits;

    for (genvar i = 0; i < NSRC; i++) begin : g_en
        localparam int POS = src_pos(i);
        assign en_bits[i] = en_wdata[POS];
    end

    always_ff @(posedge clk) begin
        if (rst)        en_q <= '0;
        else if (en_we) en_q <= en_bits;
    end

    assign irq_o = |(flags & en_q);

    // R7
    en_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en_we |=> $stable(en_q));

    // R8
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> !irq_o);

endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
    import fifo_irq_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH,
    parameter int REG_W = DEF_REG_W,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] rx_level,
    input  logic [CNT_W-1:0] tx_level,
    input  logic             xfer_done,
    input  logic             sts_clr_we,
    input  logic [REG_W-1:0] sts_clr_data,
    input  logic             en_we,
    input  logic [REG_W-1:0] en_wdata,
    output logic [REG_W-1:0] status_o,
    output logic [REG_W-1:0] enable_o,
    output logic             irq_o,
    output logic [REG_W-1:0] fifo_word_o
);

    localparam int RX_HI = (DEPTH * 3) / 4;
    localparam logic [REG_W-1:0] SRC_MASK = src_mask();

    evt_t               evt;
    logic [NUM_SRC-1:0] flag_q;
    logic [NUM_SRC-1:0] en_q;
    logic               unused_wbits;

    assign unused_wbits = ^{sts_clr_data & ~SRC_MASK, en_wdata & ~SRC_MASK};

    fifo_irq_thresh #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_thresh (
        .rx_level  (rx_level),
        .tx_level  (tx_level),
        .done_pulse(xfer_done),
        .evt       (evt)
    );

    fifo_irq_flags #(.REG_W(REG_W), .NSRC(NUM_SRC)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_i   (evt),
        .clr_we  (sts_clr_we),
        .clr_data(sts_clr_data),
        .flag_q  (flag_q)
    );

    fifo_irq_mask #(.REG_W(REG_W), .NSRC(NUM_SRC)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .en_we   (en_we),
        .en_wdata(en_wdata),
        .flags   (flag_q),
        .en_q    (en_q),
        .irq_o   (irq_o)
    );

    // Spread the compact flag and enable vectors to their register positions
    always_comb begin
        status_o = '0;
        enable_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            status_o[src_pos(i)] = flag_q[i];
            enable_o[src_pos(i)] = en_q[i];
        end
    end

    always_comb begin
        fifo_word_o = '0;
        fifo_word_o[RX_CNT_LSB +: CNT_W] = rx_level;
        fifo_word_o[TX_CNT_LSB +: CNT_W] = tx_level;
    end

    // R2
    rx_high_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_level >= CNT_W'(RX_HI)) |=> status_o[src_pos(SRC_RXF)]);

    // R4
    done_sets_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> status_o[src_pos(SRC_DONE)]);

    // R8
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (status_o == '0) |-> !irq_o);

    // R11
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (status_o & ~SRC_MASK) == '0);

endmodule

// File: tb/fifo_irq_ctrl_bench.sv
module fifo_irq_ctrl_bench;

    localparam logic [31:0] MASK = 32'h0001_1010;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  rx_level = '0;
    logic [6:0]  tx_level = 7'd40;
    logic        xfer_done = 1'b0;
    logic        sts_clr_we = 1'b0;
    logic [31:0] sts_clr_data = '0;
    logic        en_we = 1'b0;
    logic [31:0] en_wdata = '0;
    logic [31:0] status_o, enable_o, fifo_word_o;
    logic        irq_o;

    always #5 clk = ~clk;

    fifo_irq_ctrl u_fifo_irq_ctrl (
        .clk(clk), .rst(rst), .rx_level(rx_level), .tx_level(tx_level),
        .xfer_done(xfer_done), .sts_clr_we(sts_clr_we),
        .sts_clr_data(sts_clr_data), .en_we(en_we), .en_wdata(en_wdata),
        .status_o(status_o), .enable_o(enable_o), .irq_o(irq_o),
        .fifo_word_o(fifo_word_o)
    );

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    logic [31:0] q_sts[$];
    logic [31:0] q_en[$];
    logic [31:0] q_word[$];
    logic        q_irq[$];
    string       q_req[$];

    logic [31:0] m_sts = '0;
    logic [31:0] m_en  = '0;

    // Driver: applies one cycle of stimulus and queues the expected outputs
    task automatic step(input string req, input int rx, input int tx,
                        input bit done, input bit cw, input logic [31:0] cd,
                        input bit ew, input logic [31:0] ed);
        logic [31:0] setv;
        @(negedge clk);
        rx_level = 7'(rx); tx_level = 7'(tx); xfer_done = done;
        sts_clr_we = cw; sts_clr_data = cd; en_we = ew; en_wdata = ed;
        setv = '0;
        if (rx >= 48) setv[4]  = 1'b1;
        if (tx <= 16) setv[12] = 1'b1;
        if (done)     setv[16] = 1'b1;
        m_sts = ((m_sts & ~(cw ? cd : 32'h0)) & MASK) | setv;
        if (ew) m_en = ed & MASK;
        @(posedge clk);
        #1;
        q_sts.push_back(m_sts);
        q_en.push_back(m_en);
        q_word.push_back({9'd0, 7'(tx), 9'd0, 7'(rx)});
        q_irq.push_back(|(m_sts & m_en));
        q_req.push_back(req);
        xfer_done = 1'b0; sts_clr_we = 1'b0; en_we = 1'b0;
    endtask

    // Monitor: pops and compares after each edge
    always @(posedge clk) begin
        #2;
        if (q_req.size() > 0) begin
            logic [31:0] es, ee, ew;
            logic ei;
            string r;
            es = q_sts.pop_front(); ee = q_en.pop_front();
            ew = q_word.pop_front(); ei = q_irq.pop_front();
            r = q_req.pop_front();
            compared++;
            if (status_o !== es || enable_o !== ee || fifo_word_o !== ew || irq_o !== ei) begin
                mismatched++;
                $display("FIFO_IRQ FAIL %s: got sts=%h en=%h word=%h irq=%b exp sts=%h en=%h word=%h irq=%b",
                         r, status_o, enable_o, fifo_word_o, irq_o, es, ee, ew, ei);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            compared++; mismatched++;
            $display("FIFO_IRQ FAIL watchdog: got hang exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs under reset
        compared++;
        if (status_o !== 0 || enable_o !== 0 || irq_o !== 0) begin
            mismatched++;
            $display("FIFO_IRQ FAIL R1: got sts=%h en=%h irq=%b exp 0 0 0", status_o, enable_o, irq_o);
        end
        rst = 1'b0;
        step("R1", 0, 40, 0, 0, 0, 0, 0);
        // R2 threshold edges
        step("R2", 47, 40, 0, 0, 0, 0, 0);
        step("R2", 48, 40, 0, 0, 0, 0, 0);
        step("R2", 20, 40, 0, 0, 0, 0, 0);
        step("R5", 20, 40, 0, 1, 32'h0000_0010, 0, 0);
        // R3 threshold edges
        step("R3", 0, 17, 0, 0, 0, 0, 0);
        step("R3", 0, 16, 0, 0, 0, 0, 0);
        step("R3", 0, 40, 0, 0, 0, 0, 0);
        // R6 clear while condition holds
        step("R6", 60, 40, 0, 0, 0, 0, 0);
        step("R6", 60, 0, 0, 1, 32'h0000_1010, 0, 0);
        step("R6", 0, 40, 0, 1, 32'h0000_1010, 0, 0);
        // R4 pulse latch
        step("R4", 0, 40, 1, 0, 0, 0, 0);
        step("R4", 0, 40, 0, 0, 0, 0, 0);
        // R5 selective and full clear
        step("R5", 0, 10, 0, 0, 0, 0, 0);
        step("R5", 0, 40, 0, 1, 32'hFFFE_FFFF, 0, 0);
        step("R5", 0, 40, 0, 1, 32'hFFFF_FFFF, 0, 0);
        // R10 pulse coincides with clear
        step("R10", 0, 40, 1, 1, 32'h0001_0000, 0, 0);
        // R7 R8 enables and interrupt
        step("R7", 0, 40, 0, 0, 0, 1, 32'hFFFF_FFFF);
        step("R8", 0, 40, 0, 1, 32'hFFFF_FFFF, 0, 0);
        step("R8", 50, 40, 0, 1, 0, 1, 32'h0001_0000);
        step("R8", 50, 40, 0, 0, 0, 1, 32'h0000_0010);
        step("R7", 50, 40, 0, 0, 0, 1, 32'hFFFE_EFEF);
        // R9 packed word and R11 reserved bits
        step("R9", 64, 64, 0, 1, 32'hFFFF_FFFF, 0, 0);
        step("R9", 5, 33, 0, 1, 32'hFFFF_FFFF, 0, 0);
        step("R11", 0, 40, 1, 1, 32'h0000_0000, 0, 0);
        repeat (3) @(posedge clk);
        #3;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule